// File: doc/BRIEF.md
# Ring-Sequenced Successive Approximation Controller

This block is the digital sequencer of a successive approximation converter. An accepted start pulse puts a single token into a one-hot ring of `WIDTH+2` stages. While the token moves from one stage to the next, per-bit set/reset flip-flops build a trial word. That word drives an external DAC directly. A single comparator bit reports whether the DAC output lies above the held analog input. Each ring stage does two things on the same edge: it judges the bit set one stage earlier and it sets the next lower bit. The conversion therefore takes one clock per bit, plus a first stage that sets the MSB and a final stage that presents the answer.

The controller has two named states. `CTL_IDLE` waits for `start_i`. The transition *launch* (`CTL_IDLE` to `CTL_CONVERT`, taken when `start_i` is high) injects the token and clears the trial and result words. The transition *retire* (`CTL_CONVERT` to `CTL_IDLE`, taken when the token sits in the final stage) ends the conversion. In the final stage the trial word is gated onto the result port and a one-clock done flag is raised. The result then holds until the next launch. The reference configuration is 3 bits with a 5-stage ring.

Top module: `sar_ring_ctrl`

## Requirements
- R1: After synchronous reset, `trial_o`, `result_o` and `done_o` are all zero and the controller is in `CTL_IDLE`.
- R2: A start sampled in `CTL_IDLE` clears `trial_o` and `result_o` on that edge. On the next edge, only the MSB of `trial_o` becomes 1.
- R3: In the stage after a bit was set, that bit is cleared when `cmp_above_i` is 1 (1 means the DAC output is above the input) and kept when it is 0. On the same edge, the next lower bit is set, if one exists.
- R4: `done_o` is high for exactly one clock: the `WIDTH+2`-th cycle after the edge that accepted start.
- R5: While `done_o` is high, `result_o` equals `trial_o`. Afterwards it holds that value until the next accepted start.
- R6: A start that arrives while `CTL_CONVERT` is active, including in the final stage, has no effect on `trial_o`, `result_o` or `done_o` timing.
- R7: With an ideal DAC (code c gives level c) and an input level v, the result is min(v, 2^WIDTH-1). So full scale gives all ones and zero gives all zeros.
- R8: After the conversion, `trial_o` keeps the final code until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, honoured only in `CTL_IDLE` |
| cmp_above_i | input | 1 | Comparator: 1 when the DAC output exceeds the input |
| trial_o | output | WIDTH | Trial word to the DAC |
| result_o | output | WIDTH | Gated parallel result, held between conversions |
| done_o | output | 1 | One-clock end-of-conversion flag |

## Verification
Two functions share every middle ring stage: judging bit k and setting bit k-1. The bench drives a behavioural comparator from the trial word. It chooses input levels so that clearing and setting land on the same edge, and also so that they do not. After every edge it compares the whole trial word against a bench model of the binary search. A second collision occurs when a start request lands in the final stage, the cycle in which the controller retires. The bench provokes this and then expects no relaunch: the trial word and result keep their values and `done_o` falls.

// File: rtl/sar_ring_pkg.sv
package sar_ring_pkg;

    typedef enum logic {
        CTL_IDLE    = 1'b0,
        CTL_CONVERT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/sar_token_ring.sv
module sar_token_ring #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inject,
    output logic [STAGES-1:0] ring
);

    // Single-token shifter: token enters stage 0 and falls off after the last stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            ring <= '0;
        end else begin
            ring <= {ring[STAGES-2:0], inject};
        end
    end

    p_ring_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ring));

    p_ring_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (ring[STAGES-2] && !inject) |=> (ring[STAGES-1] && !ring[0]));

endmodule

// File: rtl/sar_result_cell.sv
module sar_result_cell (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_en,
    input  logic drop_en,
    output logic q
);

    // Set/reset flip-flop with clear; the set and drop of one bit never coincide.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (drop_en) begin
            q <= 1'b0;
        end else if (set_en) begin
            q <= 1'b1;
        end
    end

    p_drop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (drop_en && !clr) |=> !q);

    p_set_raises_r2: assert property (@(posedge clk) disable iff (rst)
        (set_en && !drop_en && !clr) |=> q);

    p_no_set_drop_clash_r3: assert property (@(posedge clk) disable iff (rst)
        !(set_en && drop_en));

endmodule

// File: rtl/sar_output_gate.sv
module sar_output_gate #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             final_stage,
    input  logic             pre_final,
    input  logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] gated;

    // AND gating of the trial word by the final ring stage.
    always_comb begin
        gated = trial & {WIDTH{final_stage}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (clr) begin
            hold_q <= '0;
        end else if (final_stage) begin
            hold_q <= gated;
        end
    end

    always_comb begin
        done   = final_stage;
        result = final_stage ? gated : hold_q;
    end

    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !pre_final) |=> $stable(result));

    p_done_matches_trial_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (result == trial));

endmodule

// File: rtl/sar_ring_ctrl.sv
module sar_ring_ctrl #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_above_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    import sar_ring_pkg::*;

    localparam int STAGES = WIDTH + 2;
    localparam int LAST   = STAGES - 1;

    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic              launch;
    logic [STAGES-1:0] ring;
    logic [WIDTH-1:0]  trial;

    // Next-state and launch decode.
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            CTL_IDLE: begin
                if (start_i) begin
                    state_d = CTL_CONVERT;
                    launch  = 1'b1;
                end
            end
            CTL_CONVERT: begin
                if (ring[LAST]) begin
                    state_d = CTL_IDLE;
                end
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    sar_token_ring #(
        .STAGES(STAGES)
    ) u_ring (
        .clk   (clk),
        .rst   (rst),
        .inject(launch),
        .ring  (ring)
    );

    // Bit i is set by ring stage WIDTH-1-i and judged by stage WIDTH-i.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic set_en;
        logic drop_en;

        always_comb begin
            set_en  = ring[WIDTH-1-i];
            drop_en = ring[WIDTH-i] & cmp_above_i;
        end

        sar_result_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .clr    (launch),
            .set_en (set_en),
            .drop_en(drop_en),
            .q      (trial[i])
        );
    end

    sar_output_gate #(
        .WIDTH(WIDTH)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .clr        (launch),
        .final_stage(ring[LAST]),
        .pre_final  (ring[LAST-1]),
        .trial      (trial),
        .result     (result_o),
        .done       (done_o)
    );

    // Output assignment.
    always_comb begin
        trial_o = trial;
    end

    p_launch_clears_r2: assert property (@(posedge clk) disable iff (rst)
        launch |=> (trial_o == '0 && result_o == '0));

    p_msb_after_launch_r2: assert property (@(posedge clk) disable iff (rst)
        ring[0] |=> (trial_o == {1'b1, {(WIDTH-1){1'b0}}}));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTL_CONVERT && start_i) |=> !ring[0]);

    p_idle_ring_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTL_IDLE) |-> (ring == '0));

    p_trial_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTL_IDLE && !start_i) |=> $stable(trial_o));

endmodule

// File: tb/test_sar_ring_ctrl.sv
module test_sar_ring_ctrl;

    localparam int W     = 3;
    localparam int STG   = W + 2;
    localparam int FULL  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cmp_above_i;
    logic [W-1:0] trial_o;
    logic [W-1:0] result_o;
    logic         done_o;

    int vin = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Behavioural ideal DAC plus comparator.
    always_comb cmp_above_i = (int'(trial_o) > vin);

    sar_ring_ctrl #(.WIDTH(W)) i_sar_ring_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_above_i(cmp_above_i),
        .trial_o    (trial_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    function automatic int exp_code(int v);
        return (v > FULL) ? FULL : v;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #2;
    endtask

    // One conversion; inj = stage (1..STG) in which a stray start is raised, 0 = none.
    task automatic convert(int v, int inj);
        int t;
        int prev_res;
        vin = v;
        start_i = 1'b1;
        edge_step();
        start_i = (inj == 1);
        t = 0;
        chk(trial_o == 0, "R2 trial cleared", trial_o, 0);
        chk(result_o == 0, "R2 result cleared", result_o, 0);
        for (int c = 1; c <= W + 1; c++) begin
            if (c == 1) begin
                t = 1 << (W - 1);
            end else begin
                int b = W - (c - 1);
                if (t > v) t = t & ~(1 << b);
                if (b > 0) t = t | (1 << (b - 1));
            end
            edge_step();
            start_i = (inj == c + 1);
            chk(trial_o == W'(t), "R3 trial step", trial_o, t);
            chk(done_o == (c + 1 == STG), "R4 done timing", done_o, int'(c + 1 == STG));
        end
        chk(result_o == W'(exp_code(v)), "R7 result code", result_o, exp_code(v));
        chk(result_o == trial_o, "R5 result gated", result_o, trial_o);
        prev_res = result_o;
        edge_step();
        start_i = 1'b0;
        chk(done_o == 1'b0, "R4 done single", done_o, 0);
        chk(result_o == W'(prev_res), "R5 result held", result_o, prev_res);
        chk(trial_o == W'(t), "R8 trial kept", trial_o, t);
        if (inj != 0) begin
            edge_step();
            chk(trial_o == W'(t) && result_o == W'(prev_res) && !done_o,
                "R6 stray start ignored", trial_o, t);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) edge_step();
        rst = 1'b0;
        chk(trial_o == 0, "R1 trial reset", trial_o, 0);
        chk(result_o == 0, "R1 result reset", result_o, 0);
        chk(done_o == 0, "R1 done reset", done_o, 0);
        edge_step();
        edge_step();
        chk(trial_o == 0 && !done_o, "R1 idle without start", trial_o, 0);

        // Directed corners.
        convert(0, 0);             // R7 zero
        convert(FULL, 0);          // R7 full scale
        convert(FULL + 3, 0);      // R7 above range
        convert(4, 0);
        convert(3, 0);
        convert(5, STG);           // R6 start in final stage
        convert(2, 2);             // R6 start mid conversion
        convert(6, 1);             // R6 start in first stage

        // Random mix.
        for (int n = 0; n < 40; n++) begin
            int v = int'($urandom_range(0, FULL + 2));
            int inj = (($urandom_range(0, 2)) == 0) ? 0 : int'($urandom_range(1, STG));
            convert(v, inj);
            repeat (int'($urandom_range(0, 2))) edge_step();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule